// File: doc/BRIEF.md
# Recall-Pattern Game Controller

This block runs the rules of a one-player recall game. Each round it shows a 4-bit pattern taken from a pseudo-random sequence. It also keeps the pattern that was shown in the round before. A 2-bit prompt tells the player which of the two patterns to type back. The player's 4-bit entry is judged in the cycle in which a one-cycle submit strobe is high. The verdict comes out as a one-cycle hit or miss pulse on the following cycle.

A hit moves the game to the next round. The shown pattern is copied into the previous-pattern store, the generator steps, the prompt flips and a saturating round counter goes up by one. A miss raises a game-over flag that stays set until reset. While the flag is set, the controller freezes and ignores any further entries. Debouncing, display drive and display timing belong to the surrounding logic.

Top module: `mem_game_ctrl`

## Requirements
- R1: The shown pattern comes from a 4-bit generator seeded with 0001. Bits [3:0] hold positions 4..1, with bit 0 as position 1. The next pattern is {p[2:0], p[2]^p[3]}. The generator runs through all 15 non-zero values, returns to 0001 after 15 steps, and never shows 0000.
- R2: Synchronous active-high reset sets the following state: pattern 0001, prompt 10, round count 0, game-over 0, no hit or miss pulse, and the previous-pattern store cleared to 0000.
- R3: On a hit, the previous-pattern store takes the pattern that was on display, and the displayed pattern steps once.
- R4: The prompt is always 01 or 10. It flips on every hit and is 10 for the whole first round after reset.
- R5: The target is the previous pattern when the prompt is 01 and the current pattern when it is 10. An entry is a hit only when all 4 bits equal the target.
- R6: hit_o or miss_o is high for exactly the one cycle after an accepted submit. Neither is ever high without one, and the two are never high together.
- R7: A miss sets game_over_o, which stays set until reset. No further round advances after it.
- R8: While game_over_o is set, submits produce no pulse, and the pattern, prompt and round count hold.
- R9: The 8-bit round count goes up by one on each hit and holds at 255.
- R10: With submit low, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| submit_i | input | 1 | One-cycle strobe that presents entry_i for judging |
| entry_i | input | 4 | Player's 4-bit entry |
| pattern_o | output | 4 | Pattern shown this round |
| prompt_o | output | 2 | 10 = recall current, 01 = recall previous |
| hit_o | output | 1 | One-cycle pulse after a correct entry |
| miss_o | output | 1 | One-cycle pulse after a wrong entry |
| game_over_o | output | 1 | Sticky end-of-game flag |
| round_o | output | 8 | Number of rounds won, saturating |

## Verification
Two pairs of functions can meet in the same cycle.

The first pair is a hit arriving while the round count already sits at 255. The bench plays more than 255 correct rounds so that several hits land on a saturated counter. In each of those cycles the pattern and the prompt must still advance while the count stays at 255.

The second pair is a miss followed on the very next cycle by another submit. That second strobe reaches the block on the same edge at which game-over rises. A cycle-by-cycle reference model judges every output on every clock, so any advance or pulse caused by the late strobe is reported.

// File: rtl/mgc_pkg.sv
package mgc_pkg;

    localparam int PAT_W = 4;

    typedef logic [PAT_W-1:0] pat_t;

    localparam pat_t SEED = pat_t'(1);

    typedef enum logic [1:0] {
        PR_PREV = 2'b01,
        PR_CUR  = 2'b10
    } prompt_e;

    typedef struct packed {
        logic hit;
        logic miss;
    } verdict_t;

    // New bit = positions 3 and 4 combined; all bits move up one place.
    function automatic pat_t lfsr_step(input pat_t s);
        return {s[PAT_W-2:0], s[PAT_W-2] ^ s[PAT_W-1]};
    endfunction

    function automatic prompt_e prompt_flip(input prompt_e p);
        return (p == PR_CUR) ? PR_PREV : PR_CUR;
    endfunction

endpackage

// File: rtl/mgc_pattern_store.sv
module mgc_pattern_store
    import mgc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic advance_i,
    output pat_t cur_o,
    output pat_t prev_o
);

    pat_t cur_q;
    pat_t prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q  <= SEED;
            prev_q <= '0;
        end else if (advance_i) begin
            prev_q <= cur_q;
            cur_q  <= lfsr_step(cur_q);
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/mgc_target_cmp.sv
module mgc_target_cmp
    import mgc_pkg::*;
(
    input  prompt_e prompt_i,
    input  pat_t    cur_i,
    input  pat_t    prev_i,
    input  pat_t    entry_i,
    output logic    equal_o
);

    logic pick_prev;
    pat_t target;
    pat_t diff;

    assign pick_prev = (prompt_i == PR_PREV);

    for (genvar b = 0; b < PAT_W; b++) begin : g_bit
        assign target[b] = pick_prev ? prev_i[b] : cur_i[b];
        assign diff[b]   = target[b] ^ entry_i[b];
    end

    assign equal_o = (diff == '0);

endmodule

// File: rtl/mgc_round_ctr.sv
module mgc_round_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            count_q <= '0;
        end else if (inc_i && (count_q != TOP)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/mem_game_ctrl.sv
module mem_game_ctrl
    import mgc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             submit_i,
    input  logic [3:0]       entry_i,
    output logic [3:0]       pattern_o,
    output logic [1:0]       prompt_o,
    output logic             hit_o,
    output logic             miss_o,
    output logic             game_over_o,
    output logic [CNT_W-1:0] round_o
);

    pat_t     cur_pat;
    pat_t     prev_q;
    prompt_e  prompt_q;
    logic     over_q;
    verdict_t verdict_q;
    logic     equal;
    logic     accept;
    logic     advance;
    logic     fail;

    assign accept  = submit_i && !over_q;
    assign advance = accept && equal;
    assign fail    = accept && !equal;

    mgc_pattern_store u_store (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .advance_i (advance),
        .cur_o     (cur_pat),
        .prev_o    (prev_q)
    );

    mgc_target_cmp u_cmp (
        .prompt_i (prompt_q),
        .cur_i    (cur_pat),
        .prev_i   (prev_q),
        .entry_i  (pat_t'(entry_i)),
        .equal_o  (equal)
    );

    mgc_round_ctr #(.CNT_W(CNT_W)) u_rounds (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .inc_i   (advance),
        .count_o (round_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prompt_q  <= PR_CUR;
            over_q    <= 1'b0;
            verdict_q <= '0;
        end else begin
            verdict_q.hit  <= advance;
            verdict_q.miss <= fail;
            if (advance) begin
                prompt_q <= prompt_flip(prompt_q);
            end
            if (fail) begin
                over_q <= 1'b1;
            end
        end
    end

    assign pattern_o   = cur_pat;
    assign prompt_o    = prompt_q;
    assign hit_o       = verdict_q.hit;
    assign miss_o      = verdict_q.miss;
    assign game_over_o = over_q;

endmodule

// File: rtl/mgc_checker.sv
module mgc_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [3:0]       pattern_i,
    input logic [3:0]       prev_i,
    input logic [1:0]       prompt_i,
    input logic             hit_i,
    input logic             miss_i,
    input logic             over_i,
    input logic [CNT_W-1:0] round_i
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    a_r1_nonzero: assert property (@(posedge clk_i) disable iff (rst_i)
        pattern_i != 4'b0000);

    a_r4_prompt_code: assert property (@(posedge clk_i) disable iff (rst_i)
        (prompt_i == 2'b01) || (prompt_i == 2'b10));

    a_r3_prev_capture: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_i |-> (prev_i == $past(pattern_i)));

    a_r6_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
        !(hit_i && miss_i));

    a_r7_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        over_i |=> over_i);

    a_r8_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        over_i |=> ($stable(pattern_i) && $stable(prompt_i) && $stable(round_i) && !hit_i));

    a_r9_saturate: assert property (@(posedge clk_i) disable iff (rst_i)
        (round_i == TOP) |=> (round_i == TOP));

endmodule

bind mem_game_ctrl mgc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .pattern_i (pattern_o),
    .prev_i    (prev_q),
    .prompt_i  (prompt_o),
    .hit_i     (hit_o),
    .miss_i    (miss_o),
    .over_i    (game_over_o),
    .round_i   (round_o)
);

// File: tb/mem_game_ctrl_test.sv
`timescale 1ns/1ps
module mem_game_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       submit;
    logic [3:0] entry;
    logic [3:0] pattern;
    logic [1:0] prompt;
    logic       hit, miss, over;
    logic [7:0] round;

    int n_checks = 0;
    int n_fails  = 0;

    // reference model state
    int m_cur, m_prev, m_pr, m_over, m_rnd, m_hit, m_miss;

    always #4 clk = ~clk;

    mem_game_ctrl uut (
        .clk_i(clk), .rst_i(rst), .submit_i(submit), .entry_i(entry),
        .pattern_o(pattern), .prompt_o(prompt), .hit_o(hit), .miss_o(miss),
        .game_over_o(over), .round_o(round)
    );

    function automatic int next_pat(int p);
        int nb;
        nb = ((p >> 2) ^ (p >> 3)) & 1;
        return ((p << 1) & 15) | nb;
    endfunction

    task automatic chk(string tag, string what, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic model_clock(bit r, bit s, int e);
        if (r) begin
            m_cur = 1; m_prev = 0; m_pr = 2; m_over = 0; m_rnd = 0;
            m_hit = 0; m_miss = 0;
        end else begin
            m_hit = 0; m_miss = 0;
            if (s && m_over == 0) begin
                if (e == ((m_pr == 1) ? m_prev : m_cur)) begin
                    m_hit = 1;
                    m_prev = m_cur;
                    m_cur = next_pat(m_cur);
                    m_pr = (m_pr == 2) ? 1 : 2;
                    if (m_rnd < 255) m_rnd++;
                end else begin
                    m_miss = 1;
                    m_over = 1;
                end
            end
        end
    endtask

    // one clock: drive at negedge, advance model at posedge, compare 1 ns later
    task automatic step(bit r, bit s, int e, string tag);
        @(negedge clk);
        rst = r; submit = s; entry = e[3:0];
        @(posedge clk);
        model_clock(r, s, e);
        #1;
        chk("R1", {tag, " pattern"}, pattern, m_cur);
        chk("R4", {tag, " prompt"}, prompt, m_pr);
        chk("R6", {tag, " hit"}, hit, m_hit);
        chk("R6", {tag, " miss"}, miss, m_miss);
        chk("R7", {tag, " game_over"}, over, m_over);
        chk("R9", {tag, " round"}, round, m_rnd);
    endtask

    function automatic int good_entry();
        return (m_pr == 1) ? m_prev : m_cur;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        int start_pat;
        rst = 1'b1; submit = 1'b0; entry = 4'd0;
        m_cur = 1; m_prev = 0; m_pr = 2; m_over = 0; m_rnd = 0; m_hit = 0; m_miss = 0;

        // R2: reset state
        step(1, 0, 0, "R2 reset");
        step(1, 0, 0, "R2 reset");
        chk("R2", "pattern after reset", pattern, 1);
        chk("R2", "prompt after reset", prompt, 2);

        // R10: idle cycles change nothing
        for (int i = 0; i < 4; i++) step(0, 0, 9, "R10 idle");

        // R4: first round asks for current pattern; R5 entry equal to cleared prev misses nothing
        chk("R4", "first-round prompt", prompt, 2);

        // R1/R3/R5: 20 correct rounds, alternating prompts, spaced and back-to-back
        start_pat = pattern;
        for (int i = 0; i < 20; i++) begin
            step(0, 1, good_entry(), "R3 correct");
            if (i == 14) chk("R1", "period 15 return", pattern, start_pat);
            if (i % 3 == 0) step(0, 0, 0, "R6 gap");
        end
        chk("R9", "round after 20 hits", round, 20);

        // R5: with prompt 01, typing the current pattern must miss
        if (m_pr == 2) step(0, 1, good_entry(), "R5 align");
        chk("R5", "prompt is previous", prompt, 1);
        step(0, 1, pattern, "R5 wrong target");
        chk("R7", "game over after miss", over, 1);
        // R8: submit right on the edge game-over rises, then more strobes
        step(0, 1, good_entry(), "R8 late strobe");
        for (int i = 0; i < 5; i++) step(0, 1, i, "R8 ignored");
        step(0, 0, 0, "R8 idle");

        // R2: reset clears game over
        step(1, 0, 0, "R2 re-reset");
        chk("R2", "game over cleared", over, 0);
        step(0, 0, 0, "R10 idle");

        // R5: first-round wrong entry (previous store is 0000)
        step(0, 1, 0, "R5 zero entry");
        step(1, 0, 0, "R2 re-reset");

        // R9: saturation at 255 with hits still advancing pattern/prompt
        for (int i = 0; i < 262; i++) step(0, 1, good_entry(), "R9 long run");
        chk("R9", "saturated round", round, 255);
        step(0, 1, good_entry() ^ 8, "R7 final miss");
        step(0, 0, 0, "R7 hold");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule